// File: doc/BRIEF.md
# Dual-Bank Divided Clock Output Controller

This block takes one fast source clock and produces two banks of divided clocks. Each bank has three output lines. A small register file holds eight complete output settings, and a 3-bit select input picks the active one. For each bank, a setting gives an integer division ratio, a drive-strength flag and an enable bit for each of the bank's three lines. All three lines of a bank come from one divider flop, so they switch together.

Changing the select value, or rewriting the selected entry, never cuts a clock pulse short. A bank picks up the new setting only when its divider finishes the current output period. An active-low power-down input stops both dividers and forces every output enable low. When power-down is released, each bank restarts at the beginning of a period, using the setting selected at that moment.

A write port loads the eight entries before use. Reset clears every entry. A cleared entry has ratio 0, which is treated as 2, with drive low and all lines disabled.

Top module: `clkbank_ctrl`

## Requirements
- R1: Each of the eight entries is written through `wr_en`/`wr_addr`/`wr_data`, and the entry addressed by `sel` sets both banks. The fields of `wr_data` are as follows. For bank 0, bits [5:0] are the ratio, bit [6] is drive-high and bits [9:7] are the line-enable mask. Bank 1 uses the same layout in bits [19:10]. Mask bit k enables line k of the bank, which is `clk_out[3*b+k]`.
- R2: For an even ratio N from 2 to 63, the bank's enabled lines have a period of N source cycles, high for N/2 cycles and low for N/2 cycles.
- R3: For an odd ratio N, the high phase lasts (N-1)/2 cycles and the low phase lasts (N+1)/2 cycles.
- R4: A stored ratio of 0 or 1 divides by 2.
- R5: A new setting from a change of `sel` is applied only after the bank completes its current output period. The high and low phases already under way finish at their old lengths.
- R6: In a running bank, `clk_oe` equals the active enable mask. A disabled line has `clk_out` held low. All enabled lines of a bank carry the same waveform.
- R7: `drv_hi[b]` equals the drive-high bit of bank b's active setting.
- R8: One clock edge after `pd_n` is sampled low, all six `clk_out` and `clk_oe` are 0, and they stay 0 while `pd_n` stays low.
- R9: On the first edge at which `pd_n` is sampled high again, each bank loads the currently selected entry and restarts at count zero. Its enabled lines go high and are enabled at the same edge.
- R10: While reset is asserted, all `clk_out` and `clk_oe` are 0. After reset, with no entries written, every output stays disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Source clock that both dividers count |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_n | input | 1 | Active-low power-down; low stops the dividers and disables all outputs |
| sel | input | 3 | Selects the active entry |
| wr_en | input | 1 | Write strobe for the entry file |
| wr_addr | input | 3 | Entry to write |
| wr_data | input | 20 | Entry contents, two 10-bit bank fields |
| clk_out | output | 6 | Divided clocks; bits [2:0] are bank 0, bits [5:3] are bank 1 |
| clk_oe | output | 6 | Per-line output enable; low means the line is tri-stated |
| drv_hi | output | 2 | Per-bank drive-strength flag, 1 = high drive |

## Verification
The assertions assume that `pd_n`, `sel` and the write port are synchronous to `vco_clk` and change between edges. The power-down and restart properties count edges from the sampled value of `pd_n`, so they depend on this. The bench drives every input on the falling edge and measures phase lengths by sampling on the falling edge. Each source cycle therefore gives exactly one sample. The select change is placed inside a known high phase, so the lengths of the unfinished old period are known in advance.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int DIV_W     = 6;
  localparam int BANK_OUTS = 3;
  localparam int MIN_DIV   = 2;

  typedef struct packed {
    logic [BANK_OUTS-1:0] en_mask;
    logic                 drive_hi;
    logic [DIV_W-1:0]     ratio;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);
endpackage

// File: rtl/clkbank_cfg_store.sv
module clkbank_cfg_store
  import clkbank_pkg::*;
#(
  parameter  int NUM_CFG   = 8,
  parameter  int NUM_BANKS = 2,
  localparam int SEL_W     = $clog2(NUM_CFG),
  localparam int ENTRY_W   = NUM_BANKS * CFG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_addr,
  input  logic [ENTRY_W-1:0]          wr_data,
  input  logic [SEL_W-1:0]            sel,
  output bank_cfg_t [NUM_BANKS-1:0]   cfg_o
);

  logic [ENTRY_W-1:0] entry_q [NUM_CFG];
  logic [NUM_CFG-1:0] load_en;

  always_comb begin
    for (int i = 0; i < NUM_CFG; i++) begin
      load_en[i] = wr_en && (wr_addr == SEL_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CFG; i++) entry_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (load_en[i]) entry_q[i] <= wr_data;
      end
    end
  end

  assign cfg_o = entry_q[sel];

endmodule

// File: rtl/clkbank_div.sv
module clkbank_div
  import clkbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_n,
  input  bank_cfg_t            cfg_i,
  output logic [BANK_OUTS-1:0] clk_o,
  output logic [BANK_OUTS-1:0] oe_o,
  output logic                 drv_o
);

  bank_cfg_t        cfg_q, cfg_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] eff_n, half_n;
  logic             ph_q, ph_d;
  logic             run_q, run_d;
  logic             tc;
  logic             reload;

  // effective ratio and terminal count of the active setting
  always_comb begin
    eff_n  = (cfg_q.ratio < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : cfg_q.ratio;
    half_n = eff_n >> 1;
    tc     = (cnt_q == eff_n - 1'b1);
    reload = !run_q || tc;
  end

  // next state
  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    run_d = run_q;
    cfg_d = cfg_q;
    if (!pd_n) begin
      cnt_d = '0;
      ph_d  = 1'b0;
      run_d = 1'b0;
      cfg_d = cfg_i;
    end else if (reload) begin
      cnt_d = '0;
      ph_d  = 1'b1;
      run_d = 1'b1;
      cfg_d = cfg_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
      ph_d  = (cnt_q + 1'b1) < half_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      run_q <= run_d;
      cfg_q <= cfg_d;
    end
  end

  assign oe_o  = run_q ? cfg_q.en_mask : '0;
  assign clk_o = {BANK_OUTS{ph_q}} & oe_o;
  assign drv_o = cfg_q.drive_hi;

  // counter never passes the active ratio (R2)
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < eff_n));

  // high phase ends at count N/2, giving the odd split (R3)
  p_fall_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $fell(ph_q)) |-> (cnt_q == half_n));

  // setting held until the period completes (R5)
  p_cfg_at_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && run_q && !tc) |=> $stable(cfg_q));

  // power-down silences the bank one edge later (R8)
  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (oe_o == '0 && clk_o == '0));

  // restart begins high at count zero (R9)
  p_restart_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (ph_q && cnt_q == '0));

endmodule

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
  import clkbank_pkg::*;
#(
  parameter  int NUM_CFG   = 8,
  parameter  int NUM_BANKS = 2,
  localparam int SEL_W     = $clog2(NUM_CFG),
  localparam int ENTRY_W   = NUM_BANKS * CFG_W,
  localparam int OUT_W     = NUM_BANKS * BANK_OUTS
) (
  input  logic               vco_clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [OUT_W-1:0]   clk_out,
  output logic [OUT_W-1:0]   clk_oe,
  output logic [NUM_BANKS-1:0] drv_hi
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bank_cfg_t [NUM_BANKS-1:0] cfg_sel;

  clkbank_cfg_store #(
    .NUM_CFG   (NUM_CFG),
    .NUM_BANKS (NUM_BANKS)
  ) i_store (
    .clk     (vco_clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel     (sel),
    .cfg_o   (cfg_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    clkbank_div i_div (
      .clk   (vco_clk),
      .rst_n (rst_int_n),
      .pd_n  (pd_n),
      .cfg_i (cfg_sel[b]),
      .clk_o (clk_out[b*BANK_OUTS +: BANK_OUTS]),
      .oe_o  (clk_oe[b*BANK_OUTS +: BANK_OUTS]),
      .drv_o (drv_hi[b])
    );
  end

  // outputs stay off while the internal reset is held (R10)
  always_comb begin
    if (!rst_int_n) begin
      p_reset_quiet_r10: assert (clk_oe == '0 && clk_out == '0);
    end
  end

endmodule

// File: tb/test_clkbank_ctrl.sv
`timescale 1ns/1ps
module test_clkbank_ctrl;

  logic        vco_clk = 1'b0;
  logic        rst_n, pd_n, wr_en;
  logic [2:0]  sel, wr_addr;
  logic [19:0] wr_data;
  logic [5:0]  clk_out, clk_oe;
  logic [1:0]  drv_hi;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 vco_clk = ~vco_clk;

  clkbank_ctrl i_clkbank_ctrl (
    .vco_clk (vco_clk), .rst_n (rst_n), .pd_n (pd_n), .sel (sel),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .clk_out (clk_out), .clk_oe (clk_oe), .drv_hi (drv_hi)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_entry(input logic [2:0] a,
                             input logic [5:0] d0, input logic v0, input logic [2:0] m0,
                             input logic [5:0] d1, input logic v1, input logic [2:0] m1);
    @(negedge vco_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = {m1, v1, d1, m0, v0, d0};
    @(negedge vco_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input logic [2:0] s);
    @(negedge vco_clk);
    sel = s;
    repeat (140) @(negedge vco_clk);
  endtask

  task automatic wait_rise(input int idx);
    while (clk_out[idx] !== 1'b0) @(negedge vco_clk);
    while (clk_out[idx] !== 1'b1) @(negedge vco_clk);
  endtask

  // counts samples at the current level, current one included
  task automatic run_len(input int idx, output int n);
    logic lvl;
    lvl = clk_out[idx];
    n = 1;
    forever begin
      @(negedge vco_clk);
      if (clk_out[idx] !== lvl) break;
      n++;
    end
  endtask

  task automatic check_div(input int idx, input int n, input string tag);
    int hi, lo;
    wait_rise(idx);
    run_len(idx, hi);
    run_len(idx, lo);
    chk(hi, n / 2, {tag, " high phase"});
    chk(lo, n - n / 2, {tag, " low phase"});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pd_n = 1'b1; sel = 3'd0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge vco_clk);
    chk(clk_out, 0, "R10 clk during reset");
    chk(clk_oe, 0, "R10 oe during reset");
    rst_n = 1'b1;
    repeat (10) @(negedge vco_clk);
    chk(clk_oe, 0, "R10 cleared entries keep outputs off");
    chk(clk_out, 0, "R10 cleared entries keep clocks low");
  endtask

  task automatic t_sel0;
    bit same;
    settle(3'd0);
    chk(clk_oe, 6'h3f, "R6 R1 entry0 enables");
    chk(drv_hi, 2'b10, "R7 entry0 drive");
    check_div(0, 4, "R2 ratio 4");
    check_div(3, 5, "R3 ratio 5");
    same = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge vco_clk);
      if (!(clk_out[2:0] == 3'b000 || clk_out[2:0] == 3'b111)) same = 1'b0;
      if (!(clk_out[5:3] == 3'b000 || clk_out[5:3] == 3'b111)) same = 1'b0;
    end
    chk(same, 1, "R6 lines within a bank match");
  endtask

  task automatic t_sel1;
    bit quiet;
    settle(3'd1);
    chk(clk_oe, 6'h2f, "R6 R1 entry1 enables");
    chk(drv_hi, 2'b01, "R7 entry1 drive");
    check_div(0, 2, "R2 ratio 2");
    check_div(3, 63, "R3 ratio 63");
    quiet = 1'b1;
    for (int k = 0; k < 70; k++) begin
      @(negedge vco_clk);
      if (clk_out[4] !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, 1, "R6 disabled line stays low");
  endtask

  task automatic t_sel2;
    settle(3'd2);
    chk(clk_oe, 6'h1f, "R6 entry2 enables");
    chk(drv_hi, 2'b00, "R7 entry2 drive");
    check_div(0, 2, "R4 ratio 0");
    check_div(3, 2, "R4 ratio 1");
  endtask

  task automatic t_sel4;
    settle(3'd4);
    chk(clk_oe, 6'h10, "R1 R6 entry4 enables");
    chk(drv_hi, 2'b10, "R1 R7 entry4 drive");
    chk(clk_out[3:0], 0, "R6 masked lines low");
    check_div(4, 6, "R1 entry4 ratio 6");
  endtask

  task automatic t_switch;
    int hi, lo, hi2, lo2;
    settle(3'd3);
    wait_rise(0);
    @(negedge vco_clk);
    @(negedge vco_clk);
    sel = 3'd0;
    run_len(0, hi);
    hi = hi + 2;
    run_len(0, lo);
    run_len(0, hi2);
    run_len(0, lo2);
    chk(hi, 5, "R5 old high phase completes");
    chk(lo, 5, "R5 old low phase completes");
    chk(hi2, 2, "R5 new high phase");
    chk(lo2, 2, "R5 new low phase");
  endtask

  task automatic t_powerdown;
    int hi;
    settle(3'd0);
    pd_n = 1'b0;
    @(negedge vco_clk);
    chk(clk_out, 0, "R8 clocks stop");
    chk(clk_oe, 0, "R8 enables drop");
    sel = 3'd1;
    repeat (10) @(negedge vco_clk);
    chk(clk_oe, 0, "R8 enables stay low");
    pd_n = 1'b1;
    @(negedge vco_clk);
    chk(clk_out, 6'h2f, "R9 restart high");
    chk(clk_oe, 6'h2f, "R9 restart enables");
    @(negedge vco_clk);
    chk(clk_out[0], 0, "R9 new ratio 2 from restart");
    run_len(3, hi);
    chk(hi + 1, 31, "R9 first high phase of ratio 63");
  endtask

  initial begin
    t_reset;
    write_entry(3'd0, 6'd4,  1'b0, 3'b111, 6'd5,  1'b1, 3'b111);
    write_entry(3'd1, 6'd2,  1'b1, 3'b111, 6'd63, 1'b0, 3'b101);
    write_entry(3'd2, 6'd0,  1'b0, 3'b111, 6'd1,  1'b0, 3'b011);
    write_entry(3'd3, 6'd10, 1'b0, 3'b111, 6'd7,  1'b0, 3'b111);
    write_entry(3'd4, 6'd3,  1'b0, 3'b000, 6'd6,  1'b1, 3'b010);
    t_sel0;
    t_sel1;
    t_sel2;
    t_sel4;
    t_switch;
    t_powerdown;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge vco_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-to-R10 run actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule